// File: doc/BRIEF.md
# Two-Group Interrupt Status Collector

This block collects event pulses from a hash engine and from the DMA that feeds it. It holds them in two sticky status registers and drives one interrupt line. Each group has its own status register and its own enable register. Status bits are cleared by writing 1 to them. The DMA group also passes through a one-bit unmask gate before it can reach the line.

Software programs the enables, waits for the line, then reads the status. It clears the status by writing back what it read, or by writing all ones. Two more outputs summarise the enabled pending events as "error" or "done", and error wins when both are present. Event pulses set their status bit even while that bit is disabled, so a poll still sees them.

Register access uses a plain 32-bit write strobe with an address. Reads are combinational from the address. The word map is:

| Index | Register |
|---|---|
| 0 | core status |
| 1 | core enable |
| 2 | DMA status |
| 3 | DMA enable |
| 4 | DMA unmask |

Top module: `irqhub_top`

## Requirements
- R1: After reset, all five registers read 0 and `irqOut`, `errAny` and `doneAny` are 0.
- R2: The core status has 4 bits. Bit 2 is done; bits 0, 1 and 3 are errors. A pulse on `coreEvt[i]` sets status bit i at the next clock edge, whatever the core enable holds.
- R3: The DMA status has 9 bits. Bit 0 is source done; bits 2 to 8 are errors. Bit 1 is reserved: it never sets, it reads 0, and its enable bit also reads 0.
- R4: A write to a status register clears exactly the bits written as 1 and leaves the others. Writing all ones clears the whole register, and writing back a value just read clears exactly those bits.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: `irqOut` is 1 exactly when some core bit is both pending and enabled, or (when unmasked) some DMA bit is both pending and enabled. Enables of zero keep the line low whatever the status holds.
- R7: DMA bits reach `irqOut`, `errAny` and `doneAny` only while bit 0 of the unmask register (index 4) is 1. The unmask register reads back only that bit.
- R8: `errAny` is 1 when any enabled, unmasked pending bit is an error. `doneAny` is 1 when an enabled, unmasked done bit is pending and `errAny` is 0.
- R9: Status changes show on the outputs in the cycle after the edge that captured them. Reads of indices 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word index |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr` (combinational) |
| coreEvt | input | 4 | Hash engine event pulses, one per status bit |
| dmaEvt | input | 9 | DMA event pulses, one per status bit |
| irqOut | output | 1 | Combined interrupt line |
| errAny | output | 1 | An enabled error is pending |
| doneAny | output | 1 | An enabled done is pending and no error |

## Verification
The assertions assume event pulses are synchronous to `clk`. They also assume the clear check applies only in cycles where no event pulse arrives in that group. That is why the clear property is qualified by an idle event bus: the set-wins rule (R5) would otherwise break it.

The stimulus drives pulses and writes on the falling edge, so each lasts exactly one rising edge. Same-cycle collisions are produced only in the dedicated R5 sequence.

The sweeps cover every core pattern against every core enable, and every DMA bit under both unmask settings. This includes the reserved bit 1.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;
  localparam int CORE_W = 4;
  localparam int DMA_W  = 9;

  localparam logic [CORE_W-1:0] CORE_DONE_M = 4'b0100;
  localparam logic [CORE_W-1:0] CORE_ERR_M  = 4'b1011;
  localparam logic [DMA_W-1:0]  DMA_DONE_M  = 9'h001;
  localparam logic [DMA_W-1:0]  DMA_ERR_M   = 9'h1FC;
  localparam logic [DMA_W-1:0]  DMA_VALID_M = DMA_DONE_M | DMA_ERR_M;

  localparam int IDX_CSTAT = 0;
  localparam int IDX_CEN   = 1;
  localparam int IDX_DSTAT = 2;
  localparam int IDX_DEN   = 3;
  localparam int IDX_UNMSK = 4;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CSTAT, SEL_CEN, SEL_DSTAT, SEL_DEN, SEL_UNMSK
  } rdSel_e;

  typedef struct packed {
    logic   wrCoreStat;
    logic   wrCoreEn;
    logic   wrDmaStat;
    logic   wrDmaEn;
    logic   wrUnmask;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/irqhub_ctrl.sv
module irqhub_ctrl
  import irqhub_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    stb.rdSel = SEL_NONE;
    if (regAddr == ADDR_W'(IDX_CSTAT)) begin
      stb.rdSel      = SEL_CSTAT;
      stb.wrCoreStat = regWr;
    end else if (regAddr == ADDR_W'(IDX_CEN)) begin
      stb.rdSel    = SEL_CEN;
      stb.wrCoreEn = regWr;
    end else if (regAddr == ADDR_W'(IDX_DSTAT)) begin
      stb.rdSel     = SEL_DSTAT;
      stb.wrDmaStat = regWr;
    end else if (regAddr == ADDR_W'(IDX_DEN)) begin
      stb.rdSel   = SEL_DEN;
      stb.wrDmaEn = regWr;
    end else if (regAddr == ADDR_W'(IDX_UNMSK)) begin
      stb.rdSel    = SEL_UNMSK;
      stb.wrUnmask = regWr;
    end
  end
endmodule

// File: rtl/irqhub_datapath.sv
module irqhub_datapath
  import irqhub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CORE_W-1:0] coreEvt,
  input  logic [DMA_W-1:0]  dmaEvt,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic              errAny,
  output logic              doneAny
);
  logic [CORE_W-1:0] coreStat, coreEn;
  logic [DMA_W-1:0]  dmaStat, dmaEn;
  logic              dmaUnmask;

  // Sticky status cells: a pulse sets, a write of 1 clears, set wins.
  for (genvar i = 0; i < CORE_W; i++) begin : g_core
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) coreStat[i] <= 1'b0;
      else       coreStat[i] <= coreEvt[i] | (coreStat[i] & ~(stb.wrCoreStat & wdata[i]));
    end
  end

  for (genvar i = 0; i < DMA_W; i++) begin : g_dma
    if (DMA_VALID_M[i]) begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) dmaStat[i] <= 1'b0;
        else       dmaStat[i] <= dmaEvt[i] | (dmaStat[i] & ~(stb.wrDmaStat & wdata[i]));
      end
    end else begin : g_rsvd
      assign dmaStat[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreEn    <= '0;
      dmaEn     <= '0;
      dmaUnmask <= 1'b0;
    end else begin
      if (stb.wrCoreEn) coreEn    <= wdata[CORE_W-1:0];
      if (stb.wrDmaEn)  dmaEn     <= wdata[DMA_W-1:0] & DMA_VALID_M;
      if (stb.wrUnmask) dmaUnmask <= wdata[0];
    end
  end

  logic [CORE_W-1:0] corePend;
  logic [DMA_W-1:0]  dmaPend;
  assign corePend = coreStat & coreEn;
  assign dmaPend  = dmaStat & dmaEn & {DMA_W{dmaUnmask}};

  assign irqOut  = (|corePend) | (|dmaPend);
  assign errAny  = (|(corePend & CORE_ERR_M)) | (|(dmaPend & DMA_ERR_M));
  assign doneAny = !errAny & ((|(corePend & CORE_DONE_M)) | (|(dmaPend & DMA_DONE_M)));

  always_comb begin
    rdata = '0;
    case (stb.rdSel)
      SEL_CSTAT: rdata[CORE_W-1:0] = coreStat;
      SEL_CEN:   rdata[CORE_W-1:0] = coreEn;
      SEL_DSTAT: rdata[DMA_W-1:0]  = dmaStat;
      SEL_DEN:   rdata[DMA_W-1:0]  = dmaEn;
      SEL_UNMSK: rdata[0]          = dmaUnmask;
      default:   rdata = '0;
    endcase
  end

  a_r2_core_set: assert property (@(posedge clk) disable iff (!rstN)
    (|coreEvt) |=> ((coreStat & $past(coreEvt)) == $past(coreEvt)));

  a_r3_dma_set: assert property (@(posedge clk) disable iff (!rstN)
    (|(dmaEvt & DMA_VALID_M)) |=>
      ((dmaStat & $past(dmaEvt & DMA_VALID_M)) == $past(dmaEvt & DMA_VALID_M)));

  a_r4_core_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCoreStat && coreEvt == '0) |=> ((coreStat & $past(wdata[CORE_W-1:0])) == '0));

  a_r7_masked_dma: assert property (@(posedge clk) disable iff (!rstN)
    !dmaUnmask |-> (irqOut == (|(coreStat & coreEn))));

  a_r8_line_has_class: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (errAny || doneAny));
endmodule

// File: rtl/irqhub_top.sv
module irqhub_top
  import irqhub_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [CORE_W-1:0] coreEvt,
  input  logic [DMA_W-1:0]  dmaEvt,
  output logic              irqOut,
  output logic              errAny,
  output logic              doneAny
);
  strobe_t stb;

  irqhub_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regWr   (regWr),
    .regAddr (regAddr),
    .stb     (stb)
  );

  irqhub_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wdata   (regWdata),
    .coreEvt (coreEvt),
    .dmaEvt  (dmaEvt),
    .rdata   (regRdata),
    .irqOut  (irqOut),
    .errAny  (errAny),
    .doneAny (doneAny)
  );
endmodule

// File: tb/irqhub_top_tb_top.sv
`timescale 1ns/1ps
module irqhub_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  coreEvt = '0;
  logic [8:0]  dmaEvt = '0;
  logic        irqOut, errAny, doneAny;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irqhub_top dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .coreEvt(coreEvt),
    .dmaEvt(dmaEvt), .irqOut(irqOut), .errAny(errAny), .doneAny(doneAny)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a[2:0]; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic readChk(input string req, input int a, input logic [31:0] exp);
    regAddr = a[2:0];
    #1;
    chk(req, regRdata, exp);
  endtask

  task automatic pulse(input logic [3:0] c, input logic [8:0] d);
    @(negedge clk);
    coreEvt = c; dmaEvt = d;
    @(negedge clk);
    coreEvt = '0; dmaEvt = '0;
  endtask

  task automatic outChk(input string req, input bit i, input bit e, input bit dn);
    chk({req, " irqOut"},  {31'b0, irqOut},  {31'b0, i});
    chk({req, " errAny"},  {31'b0, errAny},  {31'b0, e});
    chk({req, " doneAny"}, {31'b0, doneAny}, {31'b0, dn});
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) readChk("R1 reg", a, 32'h0);
    outChk("R1", 1'b0, 1'b0, 1'b0);

    // R2 / R6 / R8: every core pattern against every core enable, DMA path idle
    for (int en = 0; en < 16; en++) begin
      for (int pat = 0; pat < 16; pat++) begin
        logic [3:0] p, e;
        bit expE, expD;
        p = pat[3:0]; e = en[3:0];
        busWr(0, 32'hFFFF_FFFF);
        busWr(1, {28'b0, e});
        pulse(p, 9'h0);
        readChk("R2 core status", 0, {28'b0, p});
        expE = |(p & e & 4'b1011);
        expD = !expE && ((p & e & 4'b0100) != 0);
        outChk("R6/R8 core", (p & e) != 0, expE, expD);
      end
    end
    readChk("R9 core enable readback", 1, 32'hF);

    // R3 / R7: each DMA bit with unmask off and on, core disabled
    busWr(1, 32'h0);
    busWr(0, 32'hFFFF_FFFF);
    busWr(3, 32'hFFFF_FFFF);
    readChk("R3 dma enable reserved bit", 3, 32'h1FD);
    for (int m = 0; m < 2; m++) begin
      busWr(4, m);
      for (int b = 0; b < 9; b++) begin
        logic [8:0] v;
        bit live;
        v = 9'(1 << b);
        live = (m == 1) && (b != 1);
        busWr(2, 32'hFFFF_FFFF);
        pulse(4'h0, v);
        readChk("R3 dma status", 2, {23'b0, v & 9'h1FD});
        outChk("R7 dma", live, live && b >= 2, live && b == 0);
      end
    end
    busWr(4, 32'hFFFF_FFFF);
    readChk("R7 unmask readback", 4, 32'h1);

    // R4 partial clear and write-back clear
    busWr(0, 32'hFFFF_FFFF);
    pulse(4'hF, 9'h0);
    busWr(0, 32'h5);
    readChk("R4 partial clear", 0, 32'hA);
    busWr(2, 32'hFFFF_FFFF);
    pulse(4'h0, 9'h00C);
    readChk("R4 dma read", 2, 32'h00C);
    pulse(4'h0, 9'h101);
    busWr(2, 32'h00C);
    readChk("R4 write-back clear", 2, 32'h101);
    busWr(2, 32'hFFFF_FFFF);
    readChk("R4 all-ones clear", 2, 32'h0);

    // R5 collision: event and clear on the same bit in the same cycle
    busWr(0, 32'hFFFF_FFFF);
    pulse(4'h1, 9'h0);
    @(negedge clk);
    coreEvt = 4'h4; regWr = 1'b1; regAddr = 3'd0; regWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    coreEvt = '0; regWr = 1'b0; regWdata = '0;
    readChk("R5 set wins", 0, 32'h4);

    // R8 priority across groups; R9 output timing
    busWr(1, 32'hF);
    busWr(3, 32'h1FD);
    busWr(4, 32'h1);
    busWr(2, 32'hFFFF_FFFF);
    outChk("R8 done only", 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    dmaEvt = 9'h008;
    #1;
    chk("R9 not before edge", {31'b0, errAny}, 32'h0);
    @(negedge clk);
    dmaEvt = '0;
    outChk("R8 error wins", 1'b1, 1'b1, 1'b0);
    busWr(4, 32'h0);
    outChk("R7 mask hides dma error", 1'b1, 1'b0, 1'b1);
    busWr(1, 32'h0);
    outChk("R6 zero enable", 1'b0, 1'b0, 1'b0);

    // R9 unused indices
    for (int a = 5; a < 8; a++) readChk("R9 unmapped", a, 32'h0);

    finished = 1'b1;
    report();
  end
endmodule